// File: doc/BRIEF.md
# Multicycle Load/Store Core

This block is a minimal processor core that runs only two data-moving instructions, load and store, plus a halt. Every transfer between the core and memory goes through two staging registers: an address register that drives the memory address pins and a data register that drives the write-data pins and captures read data. A fixed sequencer does one register-transfer step per clock. Each instruction starts with a fetch sequence: the address register takes the program counter, the program counter steps by 4, memory is read, and the fetched word is moved from the data register into the instruction register.

The operand address is a base register plus a sign-extended 6-bit displacement, which gives a reach of -32 to +31 bytes around the base. A load reads the word at that address and writes it into the data register field's target. A store copies that register into the data register and then writes it to memory. Memory is single-port and synchronous, with read data one cycle after the address. An opcode of 63, or any opcode other than load or store, stops the core. The halt output then stays high and no more writes leave the core until reset. A combinational debug port reads any of the eight 32-bit registers.

Top module: `ldst_core`

## Requirements
- R1: While reset is low and after it, the program counter, staging registers, instruction register and all eight general registers read zero. The halt output is low, the write enable is low and the memory address is 0.
- R2: Fetch steps run in order: address register takes PC, PC grows by 4, memory read, data register captures the word, instruction register takes it. Instructions are taken from byte addresses 0, 4, 8 and so on.
- R3: The operand address is the base register selected by bits 11:9 plus bits 5:0 read as a signed value (-32..+31), taken modulo the address width, with the two low address bits forced to zero.
- R4: A load (opcode bits 31:26 equal to 1) writes the memory word at the operand address into the register selected by bits 8:6. A load may name its own base register as its target.
- R5: A store (opcode 2) first copies the register selected by bits 8:6 into the data register and then writes that value to the word at the operand address.
- R6: The memory address pins always show the address register, and the write-data pins always show the data register. At most one step strobe is active in any cycle.
- R7: Opcode 63 and every opcode other than 1 or 2 raise the halt output. Halt stays high until reset, the PC no longer changes, and no memory write occurs, even if the next word holds a store.
- R8: Instruction fields: opcode in bits 31:26, base register in bits 11:9, data register in bits 8:6, displacement in bits 5:0. Register 0 is an ordinary register.
- R9: Counting clocks from reset release, a load takes 9 cycles and a store takes 8. A halting instruction raises halt 6 cycles after its fetch starts.
- R10: The debug port returns, combinationally, the register selected by the debug select input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W (8) | Byte address to memory, driven by the address register |
| mem_wdata | output | 32 | Write data to memory, driven by the data register |
| mem_we | output | 1 | Memory write enable, one cycle per store |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| dbg_sel | input | 3 | Register select for the debug port |
| dbg_data | output | 32 | Contents of the selected register |
| halted | output | 1 | High once the core has stopped |

## Verification
Two functions can meet on one memory word in consecutive cycles: a store's write, and the fetch that reads the next instruction. A program stores a halt word over the instruction that follows the store. The original word there is a store that would corrupt another location. The bench reference model applies writes before fetches, so a pass requires the core to halt at the rewritten word, leave the guarded word untouched, and match the predicted cycle count. A second collision is a load whose target is also its base register: the address must be formed from the old value and the register must end with the loaded word.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;

  localparam int WORD_W = 32;

  localparam logic [5:0] OP_LOAD  = 6'd1;
  localparam logic [5:0] OP_STORE = 6'd2;
  localparam logic [5:0] OP_HALT  = 6'd63;

  typedef enum logic [3:0] {
    S_FMAR, S_FPC, S_FRD, S_FMDR, S_FIR, S_DEC,
    S_LRD, S_LMDR, S_LWB, S_SMDR, S_SWR, S_HALT
  } step_e;

  function automatic logic [5:0] f_op(logic [WORD_W-1:0] ir);
    return ir[31:26];
  endfunction

  function automatic logic [2:0] f_base_idx(logic [WORD_W-1:0] ir);
    return ir[11:9];
  endfunction

  function automatic logic [2:0] f_data_idx(logic [WORD_W-1:0] ir);
    return ir[8:6];
  endfunction

  function automatic logic [WORD_W-1:0] f_disp(logic [WORD_W-1:0] ir);
    return {{(WORD_W-6){ir[5]}}, ir[5:0]};
  endfunction

  function automatic logic [WORD_W-1:0] f_eff_addr(logic [WORD_W-1:0] base,
                                                  logic [WORD_W-1:0] ir);
    return base + f_disp(ir);
  endfunction

endpackage

// File: rtl/ldst_regfile.sv
`timescale 1ns/1ps
module ldst_regfile #(
  parameter int NREG  = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b,
  input  logic [IW-1:0] raddr_d,
  output logic [DW-1:0] rdata_d
);

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_d = regs[raddr_d];

endmodule

// File: rtl/ldst_ctrl.sv
`timescale 1ns/1ps
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  output logic       mar_from_pc,
  output logic       pc_inc,
  output logic       mdr_from_mem,
  output logic       ir_from_mdr,
  output logic       mar_from_ea,
  output logic       mdr_from_reg,
  output logic       reg_we,
  output logic       mem_we,
  output logic       halted
);

  step_e step, step_nx;
  logic  is_ld, is_st;

  assign is_ld = (opcode == OP_LOAD);
  assign is_st = (opcode == OP_STORE);

  always_comb begin
    step_nx = step;
    unique case (step)
      S_FMAR: step_nx = S_FPC;
      S_FPC:  step_nx = S_FRD;
      S_FRD:  step_nx = S_FMDR;
      S_FMDR: step_nx = S_FIR;
      S_FIR:  step_nx = S_DEC;
      S_DEC:  step_nx = is_ld ? S_LRD : (is_st ? S_SMDR : S_HALT);
      S_LRD:  step_nx = S_LMDR;
      S_LMDR: step_nx = S_LWB;
      S_LWB:  step_nx = S_FMAR;
      S_SMDR: step_nx = S_SWR;
      S_SWR:  step_nx = S_FMAR;
      S_HALT: step_nx = S_HALT;
      default: step_nx = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) step <= S_FMAR;
    else        step <= step_nx;
  end

  assign mar_from_pc  = (step == S_FMAR);
  assign pc_inc       = (step == S_FPC);
  assign mdr_from_mem = (step == S_FMDR) || (step == S_LMDR);
  assign ir_from_mdr  = (step == S_FIR);
  assign mar_from_ea  = (step == S_DEC) && (is_ld || is_st);
  assign mdr_from_reg = (step == S_SMDR);
  assign reg_we       = (step == S_LWB);
  assign mem_we       = (step == S_SWR);
  assign halted       = (step == S_HALT);

endmodule

// File: rtl/ldst_core.sv
`timescale 1ns/1ps
module ldst_core
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic                    mem_we,
  input  logic [WORD_W-1:0]       mem_rdata,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [WORD_W-1:0]       dbg_data,
  output logic                    halted
);

  localparam int IW = $clog2(NREG);
  localparam logic [ADDR_W-1:0] PC_STEP  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] WORD_MSK = ~ADDR_W'(3);

  logic [ADDR_W-1:0] pc, mar;
  logic [WORD_W-1:0] mdr, ir;
  logic [WORD_W-1:0] base_val, data_val;
  logic [ADDR_W-1:0] ea_word;
  logic [IW-1:0]     base_idx, data_idx;

  // step strobes, visible by name to the bound checker
  logic mar_from_pc, pc_inc, mdr_from_mem, ir_from_mdr;
  logic mar_from_ea, mdr_from_reg, reg_we, st_we;

  ldst_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (f_op(ir)),
    .mar_from_pc  (mar_from_pc),
    .pc_inc       (pc_inc),
    .mdr_from_mem (mdr_from_mem),
    .ir_from_mdr  (ir_from_mdr),
    .mar_from_ea  (mar_from_ea),
    .mdr_from_reg (mdr_from_reg),
    .reg_we       (reg_we),
    .mem_we       (st_we),
    .halted       (halted)
  );

  assign base_idx = IW'(f_base_idx(ir));
  assign data_idx = IW'(f_data_idx(ir));

  ldst_regfile #(.NREG(NREG), .DW(WORD_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .waddr   (data_idx),
    .wdata   (mdr),
    .raddr_a (base_idx),
    .rdata_a (base_val),
    .raddr_b (data_idx),
    .rdata_b (data_val),
    .raddr_d (dbg_sel),
    .rdata_d (dbg_data)
  );

  assign ea_word = ADDR_W'(f_eff_addr(base_val, ir)) & WORD_MSK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (mar_from_pc)  mar <= pc;
      if (mar_from_ea)  mar <= ea_word;
      if (pc_inc)       pc  <= pc + PC_STEP;
      if (mdr_from_mem) mdr <= mem_rdata;
      if (mdr_from_reg) mdr <= data_val;
      if (ir_from_mdr)  ir  <= mdr;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_we    = st_we;

endmodule

// File: rtl/ldst_core_chk.sv
`timescale 1ns/1ps
module ldst_core_chk
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mar_from_pc,
  input logic              pc_inc,
  input logic              mdr_from_mem,
  input logic              ir_from_mdr,
  input logic              mar_from_ea,
  input logic              mdr_from_reg,
  input logic              reg_we,
  input logic              mem_we,
  input logic              halted,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] mar,
  input logic [WORD_W-1:0] mem_wdata,
  input logic [WORD_W-1:0] data_val
);

  p_fetch_mar_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mar_from_pc |=> pc_inc && (mar == $past(pc)));

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> pc == $past(pc) + ADDR_W'(4));

  p_ir_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_from_mdr |-> $past(mdr_from_mem));

  p_ea_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mar_from_ea |=> mar[1:0] == 2'b00);

  p_ld_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(mdr_from_mem));

  p_st_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mdr_from_reg));

  p_st_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata == $past(data_val));

  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mar_from_pc, pc_inc, mdr_from_mem, ir_from_mdr,
              mar_from_ea, mdr_from_reg, reg_we, mem_we}));

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && !mem_we);

  p_halt_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

endmodule

bind ldst_core ldst_core_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mar_from_pc  (mar_from_pc),
  .pc_inc       (pc_inc),
  .mdr_from_mem (mdr_from_mem),
  .ir_from_mdr  (ir_from_mdr),
  .mar_from_ea  (mar_from_ea),
  .mdr_from_reg (mdr_from_reg),
  .reg_we       (reg_we),
  .mem_we       (mem_we),
  .halted       (halted),
  .pc           (pc),
  .mar          (mar),
  .mem_wdata    (mem_wdata),
  .data_val     (data_val)
);

// File: tb/test_ldst_core.sv
`timescale 1ns/1ps
module test_ldst_core;

  localparam int AW    = 8;
  localparam int WORDS = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_we;
  logic [31:0]   mem_rdata;
  logic [2:0]    dbg_sel = '0;
  logic [31:0]   dbg_data;
  logic          halted;

  always #4 clk = ~clk;

  ldst_core #(.ADDR_W(AW), .NREG(8)) i_ldst_core (
    .clk (clk), .rst_n (rst_n),
    .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_we (mem_we),
    .mem_rdata (mem_rdata), .dbg_sel (dbg_sel), .dbg_data (dbg_data),
    .halted (halted)
  );

  // bench memory: synchronous read, one cycle latency, plus a preload port
  logic [31:0] mem [WORDS];
  logic        ld_en = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic [31:0] ld_val = '0;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_idx] <= ld_val;
    else if (mem_we) mem[mem_addr[AW-1:2]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[AW-1:2]];
  end

  int n_vec = 0;
  int n_bad = 0;
  int wr_in_halt = 0;
  bit finished = 0;

  always @(negedge clk) if (rst_n && halted && mem_we) wr_in_halt++;

  // scoreboard
  typedef struct {
    int          kind;   // 0 register, 1 memory word, 2 cycle count
    int          idx;
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t exp_q[$];

  logic [31:0] img [WORDS];
  logic [31:0] sm  [WORDS];
  logic [31:0] sr  [8];
  int          model_cyc;
  int          run_cyc;

  function automatic logic [31:0] enc(int op, int ra, int rd, int off);
    logic [5:0] o6;
    o6 = off[5:0];
    return {op[5:0], 14'd0, ra[2:0], rd[2:0], o6};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // independent reference interpreter
  task automatic run_model();
    int pc = 0;
    for (int i = 0; i < WORDS; i++) sm[i] = img[i];
    for (int i = 0; i < 8; i++) sr[i] = '0;
    model_cyc = 0;
    for (int n = 0; n < 200; n++) begin
      logic [31:0] w;
      int op, ra, rd, off, ea;
      w  = sm[pc / 4];
      pc = (pc + 4) % 256;
      op = int'(w[31:26]); ra = int'(w[11:9]); rd = int'(w[8:6]);
      off = int'(w[5:0]);
      if (off > 31) off = off - 64;
      ea = ((int'(sr[ra][7:0]) + off + 256) % 256) / 4;
      if (op == 1) begin
        sr[rd] = sm[ea]; model_cyc += 9;
      end else if (op == 2) begin
        sm[ea] = sr[rd]; model_cyc += 8;
      end else begin
        model_cyc += 6; break;
      end
    end
  endtask

  // driver: predicts and pushes expected items
  task automatic push_expect(string tag);
    item_t it;
    run_model();
    for (int r = 0; r < 8; r++) begin
      it.kind = 0; it.idx = r; it.val = sr[r]; it.tag = tag; exp_q.push_back(it);
    end
    for (int a = 0; a < WORDS; a++) begin
      it.kind = 1; it.idx = a; it.val = sm[a]; it.tag = {tag, " R5 R7"};
      exp_q.push_back(it);
    end
    it.kind = 2; it.idx = 0; it.val = 32'(model_cyc); it.tag = "R9 cycle count";
    exp_q.push_back(it);
  endtask

  // monitor: pops and compares against the design's results
  task automatic drain();
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      if (it.kind == 0) begin
        @(negedge clk); dbg_sel = it.idx[2:0]; #1;
        check({it.tag, " R10 reg"}, dbg_data, it.val);
      end else if (it.kind == 1) begin
        check({it.tag, " mem"}, mem[it.idx], it.val);
      end else begin
        check(it.tag, 32'(run_cyc), it.val);
      end
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk); rst_n = 1'b0;
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk); ld_en = 1'b1; ld_idx = 6'(i); ld_val = img[i];
    end
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk); #1;
    // R1: reset state at the ports
    check("R1 halted", 32'(halted), 0);
    check("R1 mem_we", 32'(mem_we), 0);
    check("R1 mem_addr", 32'(mem_addr), 0);
    for (int r = 0; r < 8; r++) begin
      dbg_sel = 3'(r); #1;
      check("R1 reg clear", dbg_data, 0);
    end
  endtask

  task automatic execute(string tag);
    logic [AW-1:0] a_hold;
    push_expect(tag);
    load_and_reset();
    wr_in_halt = 0;
    rst_n = 1'b1;
    run_cyc = 0;
    while (!halted && run_cyc < 3000) begin
      @(posedge clk); run_cyc++;
      @(negedge clk);
    end
    a_hold = mem_addr;
    repeat (12) @(negedge clk);
    check("R7 halt held", 32'(halted), 1);
    check("R7 no write after halt", 32'(wr_in_halt), 0);
    check("R7 address frozen", 32'(mem_addr), 32'(a_hold));
    drain();
  endtask

  task automatic clear_img();
    for (int i = 0; i < WORDS; i++) img[i] = 32'h0BAD_0000 | 32'(i);
  endtask

  initial begin
    // program A: R3 R4 R8 offsets at both ends, own-base load, low bits dropped
    clear_img();
    img[63] = 32'h0000_00C0;
    img[48] = 32'h1111_AAAA;
    img[49] = 32'h0000_0080;
    img[50] = 32'hDEAD_BEEF;
    img[47] = 32'h4747_0047;
    img[24] = 32'h2424_2424;
    img[0]  = enc(1, 0, 1, -4);
    img[1]  = enc(1, 1, 2, 0);
    img[2]  = enc(1, 1, 3, 8);
    img[3]  = enc(1, 1, 4, -2);
    img[4]  = enc(2, 1, 2, 31);
    img[5]  = enc(2, 1, 3, -32);
    img[6]  = enc(1, 1, 5, 31);
    img[7]  = enc(1, 1, 1, 4);
    img[8]  = enc(2, 1, 4, 1);
    img[9]  = enc(1, 1, 7, -32);
    img[10] = enc(63, 0, 0, 0);
    execute("R2 R3 R4 R8");

    // program B: unknown opcode stops the core before a store
    clear_img();
    img[63] = 32'h5A5A_5A5A;
    img[0]  = enc(1, 0, 6, -4);
    img[1]  = enc(5, 0, 0, 0);
    img[2]  = enc(2, 0, 6, 0);
    img[3]  = enc(63, 0, 0, 0);
    execute("R7 unknown opcode");

    // program C: store rewrites the next instruction with a halt
    clear_img();
    img[62] = enc(63, 0, 0, 0);
    img[0]  = enc(1, 0, 6, -8);
    img[1]  = enc(2, 0, 6, 8);
    img[2]  = enc(2, 0, 6, -12);
    execute("R5 R6 store then fetch");

    // program D: high register indices, register 0 as a base
    clear_img();
    img[63] = 32'h0000_00F0;
    img[61] = 32'h6161_6161;
    img[62] = 32'h0000_0010;
    img[0]  = enc(1, 0, 7, -4);
    img[1]  = enc(1, 7, 6, 4);
    img[2]  = enc(2, 7, 6, -16);
    img[3]  = enc(1, 7, 0, 8);
    img[4]  = enc(2, 0, 7, 0);
    img[5]  = enc(63, 0, 0, 0);
    execute("R4 R8 register fields");

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule